// File: doc/BRIEF.md
# Threshold Interrupt Event Combiner

This block watches three signed axis samples (X, Y, Z) that arrive together on a sample strobe. It compares each sample with one programmable signed threshold and so gets a "high" event (sample above the threshold) and a "low" event (sample below it) for each axis. Software chooses which of the six events count, and whether the counted events combine by OR or by AND. The result drives a single registered interrupt request.

A source register shows the interrupt-active flag and the enabled event flags captured at the last evaluation. In level mode the request follows every new sample. In latched mode the request stays high once it is set, and the captured flags stay frozen, until software reads the source register. Software reaches the block through a small register bus. Writes take effect on the clock edge. Reads are combinational from the address, and a read strobe on the source address performs the clear.

Top module: `thr_irq_combiner`

## Requirements
- R1: After reset the control register (address 0), the source register (address 1) and the threshold register (address 2) read 0x00, and irq is 0. Address 3 always reads 0x00.
- R2: The threshold is an 8-bit signed value that is sign-extended to the sample width. For each axis the high event is true when sample > threshold and the low event is true when sample < threshold, both compared as signed numbers. A sample equal to the threshold raises neither event.
- R3: With control bit 7 at 0 (OR mode), the interrupt-active result is 1 when at least one enabled event is true.
- R4: With control bit 7 at 1 (AND mode), the interrupt-active result is 1 only when every enabled event is true at the same sample. With no event enabled it is always 0.
- R5: With control bit 6 at 0 (level mode), every sample strobe reloads irq and the source flags. A source read does not clear them.
- R6: With control bit 6 at 1 (latched mode), once irq is 1 the later samples change neither irq nor the source flags, until the source register is read.
- R7: In latched mode a source read (rd_en high with address 1) clears irq and the flags at that edge, and the read returns the value from before the clear. A later sample that meets the condition sets irq again.
- R8: Control bits 5..0 enable the events ZH, ZL, YH, YL, XH, XL, in that order from bit 5 down to bit 0. The source register reads {0, IA, ZH, ZL, YH, YL, XH, XL}, with bit 7 always 0 and bit 6 equal to irq.
- R9: irq changes only at an edge that has a sample strobe or a source read. A write to the control register leaves it unchanged.
- R10: A disabled event has no effect on the interrupt and its source flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe that marks a new set of axis samples |
| x_sample | input | SAMPLE_W | Signed X axis sample |
| y_sample | input | SAMPLE_W | Signed Y axis sample |
| z_sample | input | SAMPLE_W | Signed Z axis sample |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears the source register in latched mode |
| addr | input | 2 | Register address: 0 control, 1 source, 2 threshold |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the current address |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with SAMPLE_W of 12 and DATA_W of 8. The 8-bit threshold therefore has to be sign-extended before it is compared with wider samples, so negative thresholds such as -10 check the signed path across the width change, and exact-equality samples check that neither event fires. The defaults also give the full 8-bit control layout, so all six enables, both combine modes and both latch modes are driven, including AND mode with no enables and a re-trigger after a clearing read.

// File: rtl/thr_irq_combiner.sv
`timescale 1ns/1ps
module thr_irq_combiner #(
  parameter int SAMPLE_W = 12,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] x_sample,
  input  logic signed [SAMPLE_W-1:0] y_sample,
  input  logic signed [SAMPLE_W-1:0] z_sample,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       irq
);
  localparam int NUM_AX = 3;
  localparam int NUM_EV = 2 * NUM_AX;

  logic [7:0]               cfg_q;
  logic signed [DATA_W-1:0] thr_q;
  logic [NUM_EV-1:0]        flag_q;
  logic                     ia_q;

  logic signed [SAMPLE_W-1:0] thr_ext;
  logic signed [SAMPLE_W-1:0] smp [NUM_AX];
  logic [NUM_EV-1:0]          ev;
  logic [NUM_EV-1:0]          en;
  logic [NUM_EV-1:0]          hit;
  logic                       act;
  logic                       rd_src;

  assign thr_ext = SAMPLE_W'(thr_q);
  assign smp[0]  = x_sample;
  assign smp[1]  = y_sample;
  assign smp[2]  = z_sample;

  for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
    assign ev[2*a+1] = smp[a] > thr_ext;
    assign ev[2*a]   = smp[a] < thr_ext;
  end

  assign en     = cfg_q[NUM_EV-1:0];
  assign hit    = ev & en;
  assign act    = cfg_q[7] ? ((en != '0) && (hit == en)) : (|hit);
  assign rd_src = rd_en && (addr == ADDR_W'(1));
  assign irq    = ia_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      thr_q  <= '0;
      flag_q <= '0;
      ia_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        if (addr == ADDR_W'(0)) cfg_q <= wdata[7:0];
        if (addr == ADDR_W'(2)) thr_q <= wdata;
      end
      if (sample_valid && !(cfg_q[6] && ia_q && !rd_src)) begin
        ia_q   <= act;
        flag_q <= hit;
      end else if (rd_src && cfg_q[6]) begin
        ia_q   <= 1'b0;
        flag_q <= '0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(0): rdata = DATA_W'(cfg_q);
      ADDR_W'(1): rdata = DATA_W'({1'b0, ia_q, flag_q});
      ADDR_W'(2): rdata = thr_q;
      default:    rdata = '0;
    endcase
  end
endmodule

module thr_irq_combiner_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [7:0]        cfg_q
);
  logic rd_src;
  assign rd_src = rd_en && (addr == ADDR_W'(1));

  assert_irq_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !rd_src) |=> $stable(irq));

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[6] && irq && !rd_src) |=> irq);

  assert_latch_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[6] && rd_src && !sample_valid) |=> !irq);

  assert_and_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && cfg_q[7] && cfg_q[5:0] == 6'd0 && !irq) |=> !irq);

  assert_src_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(1)) |-> (rdata[7] == 1'b0 && rdata[6] == irq));
endmodule

bind thr_irq_combiner thr_irq_combiner_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .rd_en(rd_en),
  .addr(addr), .rdata(rdata), .irq(irq), .cfg_q(cfg_q)
);

// File: tb/thr_irq_combiner_bench.sv
`timescale 1ns/1ps
module thr_irq_combiner_bench;
  logic clk = 0, rst_n = 0, sample_valid = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic signed [11:0] xs = 0, ys = 0, zs = 0;
  logic [7:0] rdata;
  logic irq;

  thr_irq_combiner #(.SAMPLE_W(12), .DATA_W(8), .ADDR_W(2)) u_thr_irq_combiner (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .x_sample(xs), .y_sample(ys), .z_sample(zs),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic [7:0] rd; logic irq; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    item_t it;
    while (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (rdata !== it.rd || irq !== it.irq) begin
        errors++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.tag, rdata, irq, it.rd, it.irq);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic smp(input int x, input int y, input int z);
    xs = x[11:0]; ys = y[11:0]; zs = z[11:0];
    sample_valid = 1; step(); sample_valid = 0;
  endtask

  task automatic chk(input logic [1:0] a, input bit clr, input logic [7:0] e,
                     input logic ei, input string t);
    item_t it;
    it.rd = e; it.irq = ei; it.tag = t;
    addr = a; rd_en = clr;
    q.push_back(it);
    step(); rd_en = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    chk(0, 0, 8'h00, 0, "R1 control reset");
    chk(1, 0, 8'h00, 0, "R1 source reset");
    chk(2, 0, 8'h00, 0, "R1 threshold reset");
    chk(3, 0, 8'h00, 0, "R1 unused address");

    wr(2, 8'd10); wr(0, 8'h02);
    smp(11, 0, 0);   chk(1, 0, 8'h42, 1, "R3 OR mode XH");
    smp(10, 0, 0);   chk(1, 0, 8'h00, 0, "R2 equal raises nothing");
    smp(11, 0, 0);   chk(1, 1, 8'h42, 1, "R5 level read");
    chk(1, 0, 8'h42, 1, "R5 read does not clear");
    wr(0, 8'h20);
    smp(0, 0, 11);   chk(1, 0, 8'h60, 1, "R8 ZH position");
    wr(0, 8'h10);
    smp(0, 0, 0);    chk(1, 0, 8'h50, 1, "R8 ZL position");

    wr(2, 8'hF6); wr(0, 8'h01);
    chk(2, 0, 8'hF6, 1, "R2 threshold readback");
    smp(-11, 0, 0);  chk(1, 0, 8'h41, 1, "R2 signed low event");
    smp(-10, 0, 0);  chk(1, 0, 8'h00, 0, "R2 signed equal");
    smp(-9, 0, 0);   chk(1, 0, 8'h00, 0, "R10 disabled XH ignored");

    wr(2, 8'd5); wr(0, 8'h8A);
    smp(6, 0, 0);    chk(1, 0, 8'h02, 0, "R4 AND partial");
    smp(6, 6, 0);    chk(1, 0, 8'h4A, 1, "R4 AND all with YH");
    wr(0, 8'h80);
    smp(100, 100, 100); chk(1, 0, 8'h00, 0, "R4 AND none enabled");

    wr(0, 8'h02);
    smp(6, 0, 0);    chk(1, 0, 8'h42, 1, "R9 set before write");
    wr(0, 8'h00);
    chk(0, 0, 8'h00, 1, "R9 config write keeps irq");
    smp(6, 0, 0);    chk(1, 0, 8'h00, 0, "R10 all disabled");

    wr(0, 8'h42);
    smp(6, 0, 0);    chk(1, 0, 8'h42, 1, "R6 latch set");
    smp(0, 0, 0);    chk(1, 0, 8'h42, 1, "R6 held after inactive sample");
    wr(0, 8'h43);
    chk(0, 0, 8'h43, 1, "R8 control readback");
    smp(0, 0, 0);    chk(1, 0, 8'h42, 1, "R6 flags frozen");
    chk(1, 1, 8'h42, 1, "R7 read returns pre-clear");
    chk(1, 0, 8'h00, 0, "R7 cleared by read");
    smp(0, 0, 0);    chk(1, 0, 8'h41, 1, "R7 reassert on sample");
    chk(1, 1, 8'h41, 1, "R7 second read");
    chk(1, 0, 8'h00, 0, "R7 second clear");

    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule